// File: doc/BRIEF.md
# POST Code Capture Ring

This block records the progress codes that host firmware emits during boot. Every host I/O write to port 0x80 is captured into a 64-entry byte store that is used as a ring. The ring runs between a programmable start slot and a programmable last slot. When the pointer steps beyond the last slot, it returns to the start slot. The block sees host I/O writes that have already been decoded into a strobe, an address and a data byte. Two enables gate capture: a global function enable and an enable that accepts port 0x80 cycles.

A local processor uses a small select/write/read port to program the window and to read the pointer. It reads any stored byte by slot number. The processor keeps its own copy of the slot it last consumed. It walks forward from that copy, wrapping from the last slot to the start slot, until it reaches the current slot. At most 63 new bytes can be consumed in one pass. An optional one-clock pulse marks each captured byte.

Top module: `post_code_ring`

## Requirements
- R1: After the synchronous reset, the start slot reads 0, the last slot reads 0x3F, the current slot reads 0, and `new_code_irq` is low.
- R2: A byte is captured only when `host_wr` is high, `host_addr` equals 0x0080, `func_en` is high and `accept_en` is high, all on the same clock edge.
- R3: On a capture, the current slot becomes current+1 modulo 64. The exception is when current equals the last slot: the current slot then becomes the start slot.
- R4: The captured byte is written at the new current slot. Driving that slot on `rd_idx` returns the byte on `rd_data` one clock later.
- R5: A write to any other address, or a write while either enable is low, leaves the current slot, every stored byte and `new_code_irq` unchanged.
- R6: Register select codes are 0 for start, 1 for last, 2 for current and 3 for none. A write through `cfg_wr` updates the selected register at that clock edge, using only bits 5:0 of `cfg_wdata`. `cfg_rdata` is registered and shows the selected register one clock after `cfg_sel` is applied, with bits 7:6 zero. Code 3 reads as 0.
- R7: `new_code_irq` is high for exactly the one clock after each capture edge, and only when `irq_en` was high on that edge.
- R8: If a write to the current slot register coincides with a capture, the register write wins. The capture is dropped: no byte is stored and no pulse is raised.
- R9: With a narrowed window, captures cycle through the slots from start to last in order. A window with start equal to last keeps writing that one slot. A current slot outside the window counts upward modulo 64 until it reaches the last slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Decoded host I/O write strobe |
| host_addr | input | 16 | Host I/O address |
| host_data | input | 8 | Host I/O write data |
| func_en | input | 1 | Global capture enable |
| accept_en | input | 1 | Accept port 0x80 cycles |
| irq_en | input | 1 | Enable for the new-code pulse |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 start, 1 last, 2 current, 3 none) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Registered read of the selected register |
| rd_idx | input | 6 | Slot to read from the store |
| rd_data | output | 8 | Registered byte at `rd_idx` |
| new_code_irq | output | 1 | One-clock pulse per captured byte |

## Verification
A wrong pointer becomes visible on `cfg_rdata` two clocks after the faulty capture. It also shows up as a stored byte at an unexpected slot, seen on `rd_data` one clock after that slot is requested. A wrong gate shows in two ways: a spurious or missing pulse on `new_code_irq` in the clock right after the host write, or a pointer that moved when it should have held. The sweeps read the pointer after every single host write, so a fault surfaces at the first wrong step rather than at the end of a run.

// File: rtl/post_ring_pkg.sv
package post_ring_pkg;
  typedef enum logic [1:0] {
    SEL_BEGIN = 2'd0,
    SEL_END   = 2'd1,
    SEL_CUR   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/post_ring_ram.sv
module post_ring_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/post_ring_ptr.sv
module post_ring_ptr
  import post_ring_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture_req,
  input  logic             cfg_wr,
  input  reg_sel_e         cfg_sel,
  input  logic [IDX_W-1:0] cfg_wdata,
  output logic [IDX_W-1:0] begin_q,
  output logic [IDX_W-1:0] end_q,
  output logic [IDX_W-1:0] cur_q,
  output logic             store_en,
  output logic [IDX_W-1:0] store_idx
);
  logic cur_wr;
  logic at_end;

  assign cur_wr    = cfg_wr && (cfg_sel == SEL_CUR);
  assign at_end    = (cur_q == end_q);
  assign store_idx = at_end ? begin_q : cur_q + IDX_W'(1);
  assign store_en  = capture_req && !cur_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      begin_q <= '0;
      end_q   <= '1;
      cur_q   <= '0;
    end else begin
      if (cfg_wr && cfg_sel == SEL_BEGIN) begin_q <= cfg_wdata;
      if (cfg_wr && cfg_sel == SEL_END)   end_q   <= cfg_wdata;
      if (cur_wr)        cur_q <= cfg_wdata;
      else if (store_en) cur_q <= store_idx;
    end
  end

  a_r1_reset_values: assert property (@(posedge clk)
    rst |=> (begin_q == '0 && end_q == '1 && cur_q == '0));

  a_r3_wrap_to_begin: assert property (@(posedge clk) disable iff (rst)
    (store_en && cur_q == end_q) |=> (cur_q == $past(begin_q)));

  a_r3_step_up: assert property (@(posedge clk) disable iff (rst)
    (store_en && cur_q != end_q) |=> (cur_q == $past(cur_q) + IDX_W'(1)));

  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!capture_req && !cur_wr) |=> $stable(cur_q));

  a_r8_cfg_wins: assert property (@(posedge clk) disable iff (rst)
    cur_wr |=> (cur_q == $past(cfg_wdata)));
endmodule

// File: rtl/post_code_ring.sv
module post_code_ring
  import post_ring_pkg::*;
#(
  parameter int          DATA_W       = 8,
  parameter int          DEPTH        = 64,
  parameter int          ADDR_W       = 16,
  parameter logic [15:0] CAPTURE_ADDR = 16'h0080,
  localparam int         IDX_W        = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_data,
  input  logic              func_en,
  input  logic              accept_en,
  input  logic              irq_en,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              new_code_irq
);
  logic             capture_req;
  logic             store_en;
  logic [IDX_W-1:0] store_idx;
  logic [IDX_W-1:0] begin_q, end_q, cur_q;
  reg_sel_e         sel;
  logic             unused_wdata_hi;

  assign sel             = reg_sel_e'(cfg_sel);
  assign unused_wdata_hi = ^cfg_wdata[DATA_W-1:IDX_W];
  assign capture_req     = host_wr && (host_addr == ADDR_W'(CAPTURE_ADDR))
                           && func_en && accept_en;

  post_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk        (clk),
    .rst        (rst),
    .capture_req(capture_req),
    .cfg_wr     (cfg_wr),
    .cfg_sel    (sel),
    .cfg_wdata  (cfg_wdata[IDX_W-1:0]),
    .begin_q    (begin_q),
    .end_q      (end_q),
    .cur_q      (cur_q),
    .store_en   (store_en),
    .store_idx  (store_idx)
  );

  post_ring_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk  (clk),
    .we   (store_en),
    .waddr(store_idx),
    .wdata(host_data),
    .raddr(rd_idx),
    .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      new_code_irq <= 1'b0;
      cfg_rdata    <= '0;
    end else begin
      new_code_irq <= store_en && irq_en;
      unique case (sel)
        SEL_BEGIN: cfg_rdata <= DATA_W'(begin_q);
        SEL_END:   cfg_rdata <= DATA_W'(end_q);
        SEL_CUR:   cfg_rdata <= DATA_W'(cur_q);
        default:   cfg_rdata <= '0;
      endcase
    end
  end

  a_r7_irq_needs_capture: assert property (@(posedge clk) disable iff (rst)
    new_code_irq |-> $past(host_wr && func_en && accept_en && irq_en));

  a_r2_capture_moves_ptr: assert property (@(posedge clk) disable iff (rst)
    (capture_req && !(cfg_wr && sel == SEL_CUR) && !(cur_q == end_q && begin_q == end_q))
      |=> !$stable(cur_q));
endmodule

// File: tb/post_code_ring_bench.sv
module post_code_ring_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic [15:0] host_addr = '0;
  logic [7:0]  host_data = '0;
  logic        func_en = 1'b0, accept_en = 1'b0, irq_en = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [5:0]  rd_idx = '0;
  logic [7:0]  rd_data;
  logic        new_code_irq;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0] m_mem [64];
  logic [5:0] m_beg, m_end, m_cur;

  post_code_ring u_post_code_ring (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_data(host_data), .func_en(func_en), .accept_en(accept_en),
    .irq_en(irq_en), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .rd_idx(rd_idx), .rd_data(rd_data),
    .new_code_irq(new_code_irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [5:0] nxt();
    return (m_cur == m_end) ? m_beg : m_cur + 6'd1;
  endfunction

  task automatic host_write(input logic [15:0] a, input logic [7:0] d,
                            input logic fe, input logic ae, input logic ie);
    logic hit;
    hit = (a == 16'h0080) && fe && ae;
    host_wr = 1'b1; host_addr = a; host_data = d;
    func_en = fe; accept_en = ae; irq_en = ie;
    tick();
    host_wr = 1'b0;
    if (hit) begin
      m_cur = nxt();
      m_mem[m_cur] = d;
    end
    check(hit ? "R7 pulse" : "R5 no pulse", {7'd0, new_code_irq}, {7'd0, hit && ie});
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [7:0] v);
    cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = v;
    tick();
    cfg_wr = 1'b0;
    case (s)
      2'd0: m_beg = v[5:0];
      2'd1: m_end = v[5:0];
      2'd2: m_cur = v[5:0];
      default: ;
    endcase
  endtask

  task automatic cfg_read(input logic [1:0] s, output logic [7:0] v);
    cfg_sel = s;
    tick();
    v = cfg_rdata;
  endtask

  task automatic ram_read(input logic [5:0] i, output logic [7:0] v);
    rd_idx = i;
    tick();
    v = rd_data;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    m_beg = 6'd0; m_end = 6'd63; m_cur = 6'd0;
    for (int i = 0; i < 64; i++) m_mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {7'd0, new_code_irq}, 8'h00);
    cfg_read(2'd0, v); check("R1 begin", v, 8'h00);
    cfg_read(2'd1, v); check("R1 end", v, 8'h3F);
    cfg_read(2'd2, v); check("R1 current", v, 8'h00);
    cfg_read(2'd3, v); check("R6 none reads zero", v, 8'h00);

    // R2 R3 R4: full ring, 70 captures so every slot is written and the pointer wraps
    for (int i = 0; i < 70; i++) begin
      host_write(16'h0080, 8'(i * 7 + 3), 1'b1, 1'b1, 1'b1);
      cfg_read(2'd2, v); check("R3 current after capture", v, {2'b00, m_cur});
    end
    for (int i = 0; i < 64; i++) begin
      ram_read(6'(i), v); check("R4 stored byte", v, m_mem[i]);
    end

    // R5: rejected writes
    for (int k = 0; k < 5; k++) begin
      logic [15:0] a;
      logic fe, ae;
      a  = (k == 3) ? 16'h0081 : (k == 4) ? 16'h0180 : 16'h0080;
      fe = (k != 0) && (k != 2);
      ae = (k != 1) && (k != 2);
      host_write(a, 8'hEE, fe, ae, 1'b1);
      cfg_read(2'd2, v); check("R5 current held", v, {2'b00, m_cur});
      ram_read(nxt(), v); check("R5 RAM held", v, m_mem[nxt()]);
    end

    // R7: pulse gated by irq_en, capture still happens
    host_write(16'h0080, 8'h5A, 1'b1, 1'b1, 1'b0);
    ram_read(m_cur, v); check("R7 capture with pulse off", v, 8'h5A);

    // R6: masking and register write/read
    cfg_write(2'd1, 8'hFF);
    cfg_read(2'd1, v); check("R6 end masked", v, 8'h3F);
    cfg_write(2'd0, 8'hC5);
    cfg_read(2'd0, v); check("R6 begin masked", v, 8'h05);

    // R8: register write to current collides with capture
    cfg_wr = 1'b1; cfg_sel = 2'd2; cfg_wdata = 8'h11;
    host_wr = 1'b1; host_addr = 16'h0080; host_data = 8'hA5;
    func_en = 1'b1; accept_en = 1'b1; irq_en = 1'b1;
    tick();
    cfg_wr = 1'b0; host_wr = 1'b0;
    check("R8 no pulse", {7'd0, new_code_irq}, 8'h00);
    m_cur = 6'h11;
    cfg_read(2'd2, v); check("R8 current set", v, 8'h11);
    for (int i = 0; i < 64; i++) begin
      ram_read(6'(i), v); check("R8 nothing stored", v, m_mem[i]);
    end

    // R9: window sweeps
    for (int c = 0; c < 5; c++) begin
      logic [5:0] b, e, s;
      case (c)
        0: begin b = 6'd10; e = 6'd20; s = 6'd18; end
        1: begin b = 6'd0;  e = 6'd0;  s = 6'd0;  end
        2: begin b = 6'd40; e = 6'd63; s = 6'd60; end
        3: begin b = 6'd10; e = 6'd20; s = 6'd58; end
        default: begin b = 6'd33; e = 6'd33; s = 6'd12; end
      endcase
      cfg_write(2'd0, {2'b00, b});
      cfg_write(2'd1, {2'b11, e});
      cfg_write(2'd2, {2'b00, s});
      for (int i = 0; i < 30; i++) begin
        host_write(16'h0080, 8'(c * 40 + i), 1'b1, 1'b1, 1'b1);
        cfg_read(2'd2, v); check("R9 window pointer", v, {2'b00, m_cur});
        ram_read(m_cur, v); check("R9 window byte", v, m_mem[m_cur]);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule